// File: doc/BRIEF.md
# Masked byte-pattern packet filter bank

This block watches a received packet stream, one byte per cycle with a first-byte and a last-byte marker, and runs four independent pattern filters over it in parallel. Every filter holds three programmed parts: a mask bit for each of the first 128 byte positions, an expected byte for each of those positions, and a minimum packet length. A filter reports a hit when the packet ends, provided the filter is enabled, every byte at a masked position matched its expected value, and the packet was at least as long as the programmed length.

Software programs the filters through a write-only register port. The mask table, the value table, the four length registers and the enable register each occupy their own address region. A length register cannot be changed while its filter is enabled. The result is a per-filter hit vector and an any-hit flag, both pulsed for one cycle after the last byte of a packet. Packets may follow each other with no idle cycle between them.

Top module: `patfilt_bank`

## Requirements
- R1: There are four filters, each with its own enable bit; the enable register sits at address 0x180 with bit f enabling filter f, and a disabled filter never reports a hit.
- R2: The mask table entry for byte position i (0 to 127) sits at address 0x000+i, with bit f of the write data as filter f's mask bit; a 1 makes filter f compare the byte at position i and fail on a difference, a 0 makes that byte irrelevant to filter f.
- R3: The value table entry for position i sits at address 0x080+i; bits 8f+7 down to 8f hold the expected byte for filter f.
- R4: Only packet bytes at positions 0 to 127 (position 0 is the first-marked byte) are compared; a differing byte at position 128 or later never causes a miss.
- R5: The length of filter f is written at address 0x100+f from data bits 10:0, data bits 31:11 are dropped, and a length write while filter f is enabled leaves the length unchanged.
- R6: A filter hits only if the packet holds at least as many bytes as its length; a shorter packet misses.
- R7: A filter with length zero never hits; a filter with no mask bit set and a nonzero length hits on every packet that is long enough.
- R8: The hit vector is zero except in the single cycle that follows the clock edge accepting a last-marked byte, where it carries that packet's result.
- R9: The any-hit output equals the OR of the hit vector in every cycle.
- R10: Comparison state restarts at each first-marked byte, so back-to-back packets with no idle cycle get results that depend only on their own bytes.
- R11: Reset clears the mask table, the value table, the lengths, the enables and both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| match_o | output | 4 | Per-filter hit pulse |
| any_match_o | output | 1 | OR of the hit pulses |

## Verification
Every result of this block is due exactly one rising edge after the edge that accepts the last-marked byte: the comparison and length test finish in the same cycle as that byte and land in the output register on that edge. The bench drives each byte on a falling edge and reads the outputs on the next falling edge, so after the last byte of a packet that read sees the result, and after every other byte it must see an all-zero hit vector. Register writes take effect on the edge that accepts them, so a packet sent right after a write already sees the new setting.

// File: rtl/fflt_pkg.sv
// Package for the masked byte-pattern filter bank.
// Holds the register region codes that the write decoder and the
// top-level address layout share. Assumes a three-bit region field
// placed above the byte-position index in the write address.
package fflt_pkg;

    localparam int REGION_W = 3;
    localparam int BYTE_W   = 8;

    typedef enum logic [REGION_W-1:0] {
        RGN_MASK  = 3'b000,
        RGN_VALUE = 3'b001,
        RGN_LEN   = 3'b010,
        RGN_EN    = 3'b011
    } reg_region_t;

endpackage

// File: rtl/fflt_cfg_regs.sv
// Configuration storage for the filter bank.
// Holds the per-position mask table, the per-position value table,
// the per-filter length registers and the enable register, and
// decodes the write port into them. Presents the mask and value
// entries for one byte position chosen by rd_pos.
// Assumes NUM_FILT * BYTE_W fits in WR_W and NUM_FILT fits in the
// position index field.
module fflt_cfg_regs
    import fflt_pkg::*;
#(
    parameter int NUM_FILT  = 4,
    parameter int WIN_BYTES = 128,
    parameter int LEN_W     = 11,
    parameter int WR_W      = 32,
    localparam int IDX_W    = $clog2(WIN_BYTES),
    localparam int ADDR_W   = IDX_W + REGION_W,
    localparam int VAL_W    = NUM_FILT * BYTE_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [WR_W-1:0]                    wr_data,
    input  logic [IDX_W-1:0]                   rd_pos,
    output logic [NUM_FILT-1:0]                mask_o,
    output logic [VAL_W-1:0]                   value_o,
    output logic [NUM_FILT-1:0][LEN_W-1:0]     len_o,
    output logic [NUM_FILT-1:0]                en_o
);

    logic [NUM_FILT-1:0] mask_q [WIN_BYTES];
    logic [VAL_W-1:0]    value_q [WIN_BYTES];
    logic [LEN_W-1:0]    len_q [NUM_FILT];
    logic [NUM_FILT-1:0] en_q;

    reg_region_t      region;
    logic [IDX_W-1:0] idx;

    // Split the write address into region and index.
    always_comb begin
        region = reg_region_t'(wr_addr[ADDR_W-1:IDX_W]);
        idx    = wr_addr[IDX_W-1:0];
    end

    // Mask and value tables: cleared by reset, written per position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_BYTES; i++) begin
                mask_q[i]  <= '0;
                value_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (region == RGN_MASK) begin
                mask_q[idx] <= wr_data[NUM_FILT-1:0];
            end
            if (region == RGN_VALUE) begin
                value_q[idx] <= wr_data[VAL_W-1:0];
            end
        end
    end

    // Enable register: one bit per filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && region == RGN_EN) begin
            en_q <= wr_data[NUM_FILT-1:0];
        end
    end

    // Length registers: writable only while the owning filter is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FILT; f++) begin
                len_q[f] <= '0;
            end
        end else if (wr_en && region == RGN_LEN) begin
            for (int f = 0; f < NUM_FILT; f++) begin
                if (idx == IDX_W'(f) && !en_q[f]) begin
                    len_q[f] <= wr_data[LEN_W-1:0];
                end
            end
        end
    end

    // Read side: table entries for the current position.
    always_comb begin
        mask_o  = mask_q[rd_pos];
        value_o = value_q[rd_pos];
        en_o    = en_q;
    end

    // Flatten the length registers onto the output bundle.
    for (genvar f = 0; f < NUM_FILT; f++) begin : g_len
        assign len_o[f] = len_q[f];

        AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && region == RGN_LEN && idx == IDX_W'(f) && en_q[f])
            |=> $stable(len_q[f]))
            else $error("length changed while filter enabled"); // R5
    end

endmodule

// File: rtl/fflt_pos_tracker.sv
// Byte-position tracker for the received stream.
// Decides which stream bytes belong to a packet, gives the position
// of the current byte (zero on a first-marked byte) and the byte
// count including the current byte, saturating at its maximum.
// Assumes bytes outside a packet that are not first-marked are noise.
module fflt_pos_tracker #(
    parameter int WIN_BYTES = 128,
    parameter int LEN_W     = 11,
    localparam int CNT_W    = LEN_W + 1,
    localparam int IDX_W    = $clog2(WIN_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             acc_o,
    output logic [IDX_W-1:0] win_pos_o,
    output logic             in_win_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WIN_BYTES);

    logic             in_pkt_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;

    // Current byte acceptance, position and running count.
    always_comb begin
        acc_o     = in_valid && (in_sop || in_pkt_q);
        pos       = in_sop ? '0 : cnt_q;
        count_o   = (pos == CNT_MAX) ? pos : pos + 1'b1;
        in_win_o  = pos < WIN_LIM;
        win_pos_o = pos[IDX_W-1:0];
    end

    // Packet membership and byte count advance on accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q <= 1'b0;
            cnt_q    <= '0;
        end else if (acc_o) begin
            in_pkt_q <= !in_eop;
            cnt_q    <= count_o;
        end
    end

endmodule

// File: rtl/fflt_lane.sv
// One pattern filter lane.
// Keeps a sticky miss flag for the current packet, restarted on a
// first-marked byte, and computes the hit decision for the byte now
// presented: it is a hit only on an accepted last byte with the lane
// enabled, a nonzero length reached, and no masked mismatch.
// Assumes the caller registers hit_o.
module fflt_lane #(
    parameter int LEN_W  = 11,
    parameter int BYTE_W = 8,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              sop_i,
    input  logic              eop_i,
    input  logic              in_win_i,
    input  logic              mask_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [BYTE_W-1:0] expect_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              hit_o
);

    logic fail_q;
    logic fail_now;
    logic fail_next;
    logic long_enough;

    // Miss detection for this byte and the packet so far.
    always_comb begin
        fail_now    = in_win_i && mask_i && (data_i != expect_i);
        fail_next   = (sop_i ? 1'b0 : fail_q) || fail_now;
        long_enough = count_i >= {1'b0, len_i};
        hit_o       = acc_i && eop_i && en_i && (len_i != '0)
                      && !fail_next && long_enough;
    end

    // Sticky miss flag, advanced on accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (acc_i) begin
            fail_q <= fail_next;
        end
    end

    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !(acc_i && sop_i)) |=> fail_q)
        else $error("miss flag dropped inside a packet"); // R2

endmodule

// File: rtl/patfilt_bank.sv
// Masked byte-pattern packet filter bank, top level.
// Connects the configuration store, the position tracker and one
// lane per filter, and registers the hit vector and any-hit flag so
// both pulse in the cycle after a packet's last byte is accepted.
// Assumes in_sop and in_eop are only meaningful with in_valid.
module patfilt_bank
    import fflt_pkg::*;
#(
    parameter int NUM_FILT  = 4,
    parameter int WIN_BYTES = 128,
    parameter int LEN_W     = 11,
    parameter int WR_W      = 32,
    localparam int IDX_W    = $clog2(WIN_BYTES),
    localparam int ADDR_W   = IDX_W + REGION_W,
    localparam int CNT_W    = LEN_W + 1,
    localparam int VAL_W    = NUM_FILT * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WR_W-1:0]     wr_data,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic                in_sop,
    input  logic                in_eop,
    output logic [NUM_FILT-1:0] match_o,
    output logic                any_match_o
);

    logic                           acc;
    logic [IDX_W-1:0]               win_pos;
    logic                           in_win;
    logic [CNT_W-1:0]               count;
    logic [NUM_FILT-1:0]            mask_at;
    logic [VAL_W-1:0]               value_at;
    logic [NUM_FILT-1:0][LEN_W-1:0] len;
    logic [NUM_FILT-1:0]            en;
    logic [NUM_FILT-1:0]            hit;
    logic [NUM_FILT-1:0]            match_q;
    logic                           any_q;

    fflt_pos_tracker #(
        .WIN_BYTES (WIN_BYTES),
        .LEN_W     (LEN_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .acc_o     (acc),
        .win_pos_o (win_pos),
        .in_win_o  (in_win),
        .count_o   (count)
    );

    fflt_cfg_regs #(
        .NUM_FILT  (NUM_FILT),
        .WIN_BYTES (WIN_BYTES),
        .LEN_W     (LEN_W),
        .WR_W      (WR_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_pos  (win_pos),
        .mask_o  (mask_at),
        .value_o (value_at),
        .len_o   (len),
        .en_o    (en)
    );

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_lane
        fflt_lane #(
            .LEN_W  (LEN_W),
            .BYTE_W (BYTE_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_i    (acc),
            .sop_i    (in_sop),
            .eop_i    (in_eop),
            .in_win_i (in_win),
            .mask_i   (mask_at[f]),
            .data_i   (in_data),
            .expect_i (value_at[f*BYTE_W +: BYTE_W]),
            .len_i    (len[f]),
            .en_i     (en[f]),
            .count_i  (count),
            .hit_o    (hit[f])
        );

        AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            !en[f] |=> !match_q[f])
            else $error("disabled filter reported a hit"); // R1

        AST_ZERO_LEN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (len[f] == '0) |=> !match_q[f])
            else $error("zero-length filter reported a hit"); // R7
    end

    // Output registers: hit vector and its OR, one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            any_q   <= 1'b0;
        end else begin
            match_q <= hit;
            any_q   <= |hit;
        end
    end

    assign match_o     = match_q;
    assign any_match_o = any_q;

    AST_HIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (match_q != '0) |-> $past(acc && in_eop))
        else $error("hit pulse without a last byte"); // R8

    AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        any_q == (match_q != '0))
        else $error("any-hit disagrees with hit vector"); // R9

endmodule

// File: tb/patfilt_bank_bench.sv
// Bench for the masked byte-pattern filter bank: directed reset and
// table checks, a table of packets sent back to back, then length
// lock and zero-length corner cases.
module patfilt_bank_bench;

    localparam int NF = 4;
    localparam int AW = 10;

    // Vector: {packet bytes, flipped position (4095 = none), expected hits}
    localparam logic [27:0] VEC [13] = '{
        {12'd200, 12'hFFF, 4'b1111},
        {12'd200, 12'd2,   4'b1110},
        {12'd200, 12'd12,  4'b1101},
        {12'd200, 12'd127, 4'b1011},
        {12'd200, 12'd150, 4'b1111},
        {12'd14,  12'hFFF, 4'b0011},
        {12'd13,  12'hFFF, 4'b0001},
        {12'd3,   12'hFFF, 4'b0000},
        {12'd128, 12'hFFF, 4'b1111},
        {12'd127, 12'hFFF, 4'b1011},
        {12'd1,   12'hFFF, 4'b0000},
        {12'd20,  12'd5,   4'b1011},
        {12'd19,  12'hFFF, 4'b0011}
    };
    localparam string VEC_REQ [13] = '{
        "R7", "R2", "R2", "R4", "R4", "R6", "R6", "R6",
        "R4", "R6", "R6", "R3", "R10"
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [NF-1:0] match;
    logic          any;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    patfilt_bank u_patfilt_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .match_o     (match),
        .any_match_o (any)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return (i < 128) ? (8'(i) ^ 8'h5A) : 8'hFF;
    endfunction

    // Send one packet; check quiet outputs inside it and the result after it.
    task automatic send_pkt(input int n, input int bad, input logic [3:0] exp,
                            input string req, input bit lit = 1'b0,
                            input logic [7:0] lit_byte = 8'h00);
        bit quiet = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = lit ? lit_byte : pat(i);
            if (i == bad) b = ~b;
            in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == n - 1); in_data = b;
            @(negedge clk);
            if (i != n - 1 && match != '0) quiet = 1'b0;
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        check(quiet, "R8", "hit vector inside packet", 0, 0);
        check(match == exp, req, "hit vector", int'(match), int'(exp));
        check(any == (exp != '0), "R9", "any-hit", int'(any), int'(exp != '0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(match == '0 && any == 1'b0, "R11", "outputs in reset", int'(match), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(match == '0 && any == 1'b0, "R11", "outputs after reset", int'(match), 0);

        // R11: tables are zero after reset; filter 0 with length 1.
        wr(10'h100, 32'd1);
        wr(10'h180, 32'h1);
        send_pkt(1, -1, 4'b0001, "R11", 1'b1, 8'h55);
        wr(10'h000, 32'h1);
        send_pkt(1, -1, 4'b0001, "R11", 1'b1, 8'h00);
        send_pkt(1, -1, 4'b0000, "R2", 1'b1, 8'h01);
        wr(10'h180, 32'h0);
        send_pkt(1, -1, 4'b0000, "R1", 1'b1, 8'h00);

        // Program the bank: f0 pos 0..3, f1 pos 10..13, f2 pos 127, f3 none.
        for (int i = 0; i < 128; i++) begin
            logic [3:0] m;
            m = {1'b0, i == 127, (i >= 10 && i <= 13), i < 4};
            wr(10'(i), {28'b0, m});
            wr(10'h080 + 10'(i), {4{pat(i)}});
        end
        wr(10'h100, 32'd4);
        wr(10'h101, 32'd14);
        wr(10'h102, 32'd128);
        wr(10'h103, 32'd20);
        wr(10'h180, 32'hF);

        // Table of packets, sent back to back (R10).
        for (int v = 0; v < 13; v++) begin
            send_pkt(int'(VEC[v][27:16]), int'(VEC[v][15:4]), VEC[v][3:0], VEC_REQ[v]);
        end
        @(negedge clk);
        check(match == '0 && any == 1'b0, "R8", "hit vector when idle", int'(match), 0);

        // R5: length write while enabled is dropped.
        wr(10'h100, 32'd100);
        send_pkt(4, -1, 4'b0001, "R5");
        // R5: upper data bits dropped on a permitted write.
        wr(10'h180, 32'h0);
        wr(10'h100, 32'hFFFF_F864);
        wr(10'h180, 32'hF);
        send_pkt(99, -1, 4'b1010, "R5");
        send_pkt(100, -1, 4'b1011, "R5");

        // R7: zero length never hits.
        wr(10'h180, 32'h0);
        wr(10'h103, 32'd0);
        wr(10'h180, 32'hF);
        send_pkt(200, -1, 4'b0111, "R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule